// File: doc/BRIEF.md
# Console Receive Port

This block is the register face of a console input channel. A serial front end hands it one event at a time: either a byte with a valid strobe, or a break strobe. The port keeps the latest event in a 16-bit receive buffer, together with error flags. It also keeps a "character ready" flag and an interrupt-enable bit, and it drives a level interrupt request and a one-cycle halt request.

Software reaches the port through two word-wide locations, selected by `reg_sel`: control/status (0) and receive buffer (1). Both are accessed with simple read and write strobes. Reading the receive buffer consumes the character: the ready flag, the error bits and the interrupt are all cleared by that read. A mode input selects 7-bit or 8-bit characters.

Top module: `con_rx_port`

## Requirements
- R1: After reset, the control/status word reads 0x0000, the receive buffer reads 0x0000, and `irq` and `halt_req` are 0.
- R2: A control/status read returns the ready flag in bit 7 and the enable flag in bit 6, with every other bit 0. A control/status write changes only bit 6.
- R3: An arriving character (`rx_valid`) is stored in buffer bits 7:0 and sets the ready flag. If the enable flag is 1 after that cycle, `irq` is set.
- R4: A buffer read returns the whole stored word. On the following edge it clears the ready flag and `irq`, and clears buffer bits 15:8. Bits 7:0 are kept.
- R5: A control/status write with bit 6 = 0 clears `irq`.
- R6: A control/status write with bit 6 = 1, made while the ready flag is 1 and the enable flag is 0, sets `irq` at once.
- R7: A break strobe (`rx_break`) loads the buffer with 0xA400 (bit 15 error summary, bit 13 framing, bit 10 break; low byte 0), sets the ready flag, and pulses `halt_req` for one cycle only when `halt_en` is 1.
- R8: An arrival while the ready flag is still 1, and without a buffer read in the same cycle, also sets bit 14 (overrun) and bit 15 of the buffer.
- R9: With `mode8` = 0, bit 7 of a stored character is forced to 0. With `mode8` = 1, all 8 bits are kept.
- R10: `irq` is a level: once set it stays 1 until R4 or R5 clears it.
- R11: An arrival in the same cycle as a buffer read stores the new character without overrun and leaves the ready flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break condition strobe |
| halt_en | input | 1 | Allows a break to request a halt |
| mode8 | input | 1 | 1 = 8-bit characters, 0 = 7-bit |
| reg_sel | input | 1 | 0 = control/status, 1 = receive buffer |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid during `reg_rd` |
| irq | output | 1 | Interrupt request level |
| halt_req | output | 1 | One-cycle halt request |

## Verification
Read data is combinational, so the bench samples `reg_rdata` in the same cycle as its strobe, between the driving falling edge and the next rising edge. Every state effect — ready flag, enable flag, buffer clearing, overrun, `irq` and `halt_req` — becomes due exactly one rising edge after the strobe. The bench drives each strobe for one full cycle starting at a falling edge, and observes the result after the following falling edge. The break halt pulse is checked for presence in that one cycle and for absence one cycle later.

// File: rtl/con_rx_pkg.sv
package con_rx_pkg;
   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_DATA = 1'b1
   } con_rx_sel_e;

   typedef struct packed {
      logic arrive;
      logic brk;
      logic rd_data;
      logic ctl_wr;
      logic w_ie;
   } con_rx_evt_t;

   function automatic logic [15:0] bit_mask16(input int unsigned pos);
      logic [15:0] m;
      m = '0;
      m[pos] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/con_rx_shaper.sv
module con_rx_shaper #(
   parameter int CHAR_W     = 8,
   parameter bit ALLOW_7BIT = 1'b1
) (
   input  logic [CHAR_W-1:0] raw_ch,
   input  logic              mode8,
   output logic [CHAR_W-1:0] shaped_ch
);
   localparam int TOP = CHAR_W - 1;

   generate
      if (ALLOW_7BIT) begin : g_sel
         always_comb begin
            shaped_ch      = raw_ch;
            shaped_ch[TOP] = raw_ch[TOP] & mode8;
         end
      end else begin : g_full
         logic unused_mode;
         assign unused_mode = mode8;
         assign shaped_ch   = raw_ch;
      end
   endgenerate
endmodule

// File: rtl/con_rx_buf.sv
module con_rx_buf
   import con_rx_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int CHAR_W  = 8,
   parameter int ERR_BIT = 15,
   parameter int OVR_BIT = 14,
   parameter int FRM_BIT = 13,
   parameter int BRK_BIT = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  con_rx_evt_t       evt,
   input  logic              done,
   input  logic              mode8,
   input  logic [CHAR_W-1:0] ch,
   output logic [DATA_W-1:0] buf_q
);
   localparam logic [DATA_W-1:0] BREAK_WORD =
      DATA_W'(bit_mask16(ERR_BIT) | bit_mask16(FRM_BIT) | bit_mask16(BRK_BIT));
   localparam logic [DATA_W-1:0] OVR_WORD =
      DATA_W'(bit_mask16(ERR_BIT) | bit_mask16(OVR_BIT));
   localparam logic [DATA_W-1:0] CHAR_MASK = DATA_W'((1 << CHAR_W) - 1);

   logic [DATA_W-1:0] new_word;
   logic              overwrite;

   always_comb begin
      if (evt.brk) new_word = BREAK_WORD;
      else         new_word = DATA_W'(ch);
   end

   assign overwrite = done && !evt.rd_data;

   always_ff @(posedge clk) begin
      if (!rst_n)           buf_q <= '0;
      else if (evt.arrive)  buf_q <= new_word | (overwrite ? OVR_WORD : '0);
      else if (evt.rd_data) buf_q <= buf_q & CHAR_MASK;
   end

   AST_OVR_ON_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.arrive && done && !evt.rd_data) |=> (buf_q[OVR_BIT] && buf_q[ERR_BIT])); // R8
   AST_SEVEN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.arrive && !evt.brk && !mode8) |=> !buf_q[CHAR_W-1]); // R9
   AST_RD_DROPS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.rd_data && !evt.arrive) |=> (buf_q[DATA_W-1:CHAR_W] == '0)); // R4
endmodule

// File: rtl/con_rx_status.sv
module con_rx_status
   import con_rx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  con_rx_evt_t evt,
   input  logic        halt_en,
   output logic        done,
   output logic        ie,
   output logic        irq,
   output logic        halt_req
);
   logic ie_after;
   logic irq_n;

   assign ie_after = evt.ctl_wr ? evt.w_ie : ie;

   always_comb begin
      irq_n = irq;
      if (evt.rd_data) irq_n = 1'b0;
      if (evt.ctl_wr) begin
         if (!evt.w_ie)      irq_n = 1'b0;
         else if (done && !ie) irq_n = 1'b1;
      end
      if (evt.arrive && ie_after) irq_n = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done     <= 1'b0;
         ie       <= 1'b0;
         irq      <= 1'b0;
         halt_req <= 1'b0;
      end else begin
         if (evt.arrive)       done <= 1'b1;
         else if (evt.rd_data) done <= 1'b0;
         ie       <= ie_after;
         irq      <= irq_n;
         halt_req <= evt.brk && halt_en;
      end
   end

   AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (done && ie)); // R10
   AST_ARRIVE_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      evt.arrive |=> done); // R3
   AST_RD_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.rd_data && !evt.arrive) |=> (!done && !irq)); // R4
   AST_IE0_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.ctl_wr && !evt.w_ie) |=> !irq); // R5
   AST_LATE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.ctl_wr && evt.w_ie && done && !ie) |=> irq); // R6
   AST_HALT_NEEDS_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |-> $past(evt.brk && halt_en)); // R7
endmodule

// File: rtl/con_rx_port.sv
module con_rx_port
   import con_rx_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int CHAR_W     = 8,
   parameter int DONE_BIT   = 7,
   parameter int IE_BIT     = 6,
   parameter int ERR_BIT    = 15,
   parameter int OVR_BIT    = 14,
   parameter int FRM_BIT    = 13,
   parameter int BRK_BIT    = 10,
   parameter bit ALLOW_7BIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              rx_break,
   input  logic              halt_en,
   input  logic              mode8,
   input  logic              reg_sel,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq,
   output logic              halt_req
);
   if (DATA_W != 16) begin : g_bad_width
      $error("con_rx_port: DATA_W must be 16");
   end
   if (CHAR_W > BRK_BIT || CHAR_W < 2) begin : g_bad_char
      $error("con_rx_port: CHAR_W must lie below the flag bits");
   end
   if (DONE_BIT == IE_BIT) begin : g_bad_csr
      $error("con_rx_port: DONE_BIT and IE_BIT must differ");
   end

   con_rx_evt_t       evt;
   logic [CHAR_W-1:0] shaped;
   logic [DATA_W-1:0] buf_q;
   logic              done;
   logic              ie;
   logic [DATA_W-1:0] csr_view;

   always_comb begin
      evt         = '0;
      evt.brk     = rx_break;
      evt.arrive  = rx_valid || rx_break;
      evt.rd_data = reg_rd && (reg_sel == SEL_DATA);
      evt.ctl_wr  = reg_wr && (reg_sel == SEL_CTRL);
      evt.w_ie    = reg_wdata[IE_BIT];
   end

   con_rx_shaper #(.CHAR_W(CHAR_W), .ALLOW_7BIT(ALLOW_7BIT)) i_shaper (
      .raw_ch   (rx_data),
      .mode8    (mode8),
      .shaped_ch(shaped)
   );

   con_rx_buf #(
      .DATA_W(DATA_W), .CHAR_W(CHAR_W), .ERR_BIT(ERR_BIT),
      .OVR_BIT(OVR_BIT), .FRM_BIT(FRM_BIT), .BRK_BIT(BRK_BIT)
   ) i_buf (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (evt),
      .done (done),
      .mode8(mode8),
      .ch   (shaped),
      .buf_q(buf_q)
   );

   con_rx_status i_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .halt_en (halt_en),
      .done    (done),
      .ie      (ie),
      .irq     (irq),
      .halt_req(halt_req)
   );

   always_comb begin
      csr_view           = '0;
      csr_view[DONE_BIT] = done;
      csr_view[IE_BIT]   = ie;
   end

   assign reg_rdata = (reg_sel == SEL_DATA) ? buf_q : csr_view;

   AST_BREAK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_break |=> (buf_q[ERR_BIT] && buf_q[FRM_BIT] && buf_q[BRK_BIT]
                    && buf_q[CHAR_W-1:0] == '0)); // R7
   AST_CSR_WRITE_IE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_CTRL) |=> (ie == $past(reg_wdata[IE_BIT]))); // R2
endmodule

// File: tb/test_con_rx_port.sv
module test_con_rx_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_break = 1'b0;
   logic        halt_en = 1'b0;
   logic        mode8 = 1'b1;
   logic        reg_sel = 1'b0;
   logic        reg_rd = 1'b0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq;
   logic        halt_req;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   con_rx_port i_con_rx_port (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_break(rx_break), .halt_en(halt_en), .mode8(mode8),
      .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .halt_req(halt_req)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic rd(input logic sel, output logic [15:0] val);
      @(negedge clk);
      reg_sel = sel; reg_rd = 1'b1;
      #1 val = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic peek(input logic sel, output logic [15:0] val);
      reg_sel = sel;
      #1 val = reg_rdata;
   endtask

   task automatic wr_ctl(input logic [15:0] v);
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic send(input logic [7:0] c);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = c;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic send_brk();
      @(negedge clk);
      rx_break = 1'b1;
      @(negedge clk);
      rx_break = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      peek(1'b0, v); chk("R1 csr", v, 16'h0000);
      peek(1'b1, v); chk("R1 buf", v, 16'h0000);
      chk("R1 irq", {15'd0, irq}, 16'd0);
      chk("R1 halt", {15'd0, halt_req}, 16'd0);

      // R2 only bit 6 writable, bits 7/6 visible
      wr_ctl(16'hFFFF);
      peek(1'b0, v); chk("R2 csr after ones", v, 16'h0040);
      wr_ctl(16'h0000);
      peek(1'b0, v); chk("R2 csr after zeros", v, 16'h0000);

      // R3 R4 R9 sweep over both modes and all bytes
      for (int m = 0; m < 2; m++) begin
         mode8 = m[0];
         for (int c = 0; c < 256; c++) begin
            send(c[7:0]);
            peek(1'b0, v); chk("R3 done set", v, 16'h0080);
            rd(1'b1, v);
            chk("R9 R3 char", v, m ? 16'(c) : 16'(c & 8'h7F));
            peek(1'b0, v); chk("R4 done cleared", v, 16'h0000);
         end
      end
      mode8 = 1'b1;

      // R3 R10 R4 irq raised and held, cleared by read
      wr_ctl(16'h0040);
      send(8'h5A);
      chk("R3 irq on arrival", {15'd0, irq}, 16'd1);
      repeat (5) @(negedge clk);
      chk("R10 irq held", {15'd0, irq}, 16'd1);
      rd(1'b1, v); chk("R4 data", v, 16'h005A);
      chk("R4 irq cleared", {15'd0, irq}, 16'd0);

      // R5 clear via IE=0
      send(8'h33);
      chk("R5 irq before", {15'd0, irq}, 16'd1);
      wr_ctl(16'h0000);
      chk("R5 irq cleared", {15'd0, irq}, 16'd0);
      peek(1'b0, v); chk("R5 done kept", v, 16'h0080);

      // R6 late enable
      wr_ctl(16'h0040);
      chk("R6 irq raised", {15'd0, irq}, 16'd1);
      rd(1'b1, v); chk("R6 data", v, 16'h0033);
      wr_ctl(16'h0000);

      // R8 overrun then error bits cleared by read
      send(8'h11);
      send(8'h22);
      rd(1'b1, v); chk("R8 overrun word", v, 16'hC022);
      peek(1'b1, v); chk("R4 errors dropped", v, 16'h0022);

      // R7 break with and without halt enable
      halt_en = 1'b1;
      send_brk();
      chk("R7 halt pulse", {15'd0, halt_req}, 16'd1);
      @(negedge clk);
      chk("R7 halt one cycle", {15'd0, halt_req}, 16'd0);
      rd(1'b1, v); chk("R7 break word", v, 16'hA400);
      peek(1'b1, v); chk("R7 after read", v, 16'h0000);
      halt_en = 1'b0;
      send_brk();
      chk("R7 no halt", {15'd0, halt_req}, 16'd0);
      peek(1'b0, v); chk("R7 done", v, 16'h0080);

      // R11 arrival with simultaneous read
      @(negedge clk);
      reg_sel = 1'b1; reg_rd = 1'b1; rx_valid = 1'b1; rx_data = 8'h6C;
      #1 chk("R11 read old", reg_rdata, 16'hA400);
      @(negedge clk);
      reg_rd = 1'b0; rx_valid = 1'b0;
      peek(1'b1, v); chk("R11 new no overrun", v, 16'h006C);
      peek(1'b0, v); chk("R11 done stays", v, 16'h0080);

      // R1 reset again
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      peek(1'b1, v); chk("R1 buf after reset", v, 16'h0000);
      peek(1'b0, v); chk("R1 csr after reset", v, 16'h0000);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule